// File: doc/BRIEF.md
# Fractional M/N:D Clock-Enable Divider

This block turns a fast source clock into a slower clock-enable pulse train and a matching divided-clock level. It works entirely in the source clock domain. Two stages run in series. The first is a half-step pre-divider that can divide by 1, 1.5, 2, 2.5 and so on. The second is an M/N accumulator that passes M out of every N pre-divider enables, with the high time of the divided level set by D. Downstream logic uses `ce_o` as a clock enable and `div_level_o` wherever a registered divided clock is needed.

The configuration arrives in stored form. N is held as the complement of N−M, and D as the complement of 2·D, each masked to the counter width. The pre-divider uses a half-step code equal to 2·div−1. When the fractional stage is not in use, the pattern is a plain divide-by-pre-divider with a 50 % level. Dual-edge output is modelled as a level that toggles on every enable. New settings are taken only at an accumulator wrap, so a period that has already started always runs to its end.

Top module: `mnd_frac_divider`

## Requirements
- R1: While `rst_n` is low, `ce_o` and `div_level_o` are 0.
- R2: Pre-divider code c (field `cfg_div_code`): for c of 0 or 1 a pre-enable is raised in every source cycle. For c ≥ 2 exactly 2 pre-enables are raised in every c+1 source cycles, which is a divide by (c+1)/2.
- R3: The true N is (~`cfg_n_enc` + `cfg_m`) mod 2^MND_W. In fractional operation `ce_o` pulses exactly M times in every N pre-enables.
- R4: The requested high time is D = ((~`cfg_d_enc`) mod 2^MND_W) >> 1. In fractional operation the accumulator value after each pre-enable step is compared with the effective D. `div_level_o` is high for the steps whose value is below it, which is D of every N steps when M and N share no factor.
- R5: The effective D is first raised to at least M and then limited to at most N−M.
- R6: Fractional operation is active only when `cfg_mode` is 2'b10, M ≠ 0, M < N and the counter is built (HAS_MND=1). Otherwise `ce_o` follows every pre-enable and `div_level_o` toggles on each one, giving a 50 % duty cycle. This includes the case where all three M/N/D fields are 0.
- R7: A configuration change takes effect at the next accumulator wrap while fractional operation is active, and in the next cycle otherwise. On taking effect, both stage accumulators restart from 0 and `div_level_o` restarts low.
- R8: `ce_o` is registered. It rises in the cycle after the source edge at which its pre-enable was raised, so the first pulse after reset release appears after the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div_code | input | DIV_W | Half-step pre-divider code (2·div−1; 0 and 1 bypass) |
| cfg_mode | input | 2 | Counter mode; 2'b10 selects dual-edge fractional operation |
| cfg_m | input | MND_W | M value |
| cfg_n_enc | input | MND_W | Complement of N−M |
| cfg_d_enc | input | MND_W | Complement of 2·D |
| ce_o | output | 1 | Output clock-enable pulse |
| div_level_o | output | 1 | Registered divided-clock level |

## Verification
Every result is due one clock edge after the pre-enable that causes it. A new configuration is due no later than the end of the period that is already running. Each scenario therefore first waits out a settling window longer than the slowest period in use. It then counts `ce_o` pulses and `div_level_o` high cycles over a window that spans a whole number of output periods, so the phase at which counting starts cannot change the totals. Timing-sensitive checks count falling edges from a known pulse: the first pulse after reset release, and the gap before and after a change made in mid-period.

// File: rtl/mnd_div_pkg.sv
package mnd_div_pkg;
   // Mode field value that selects fractional (dual-edge modelled) operation
   localparam logic [1:0] MODE_DUAL_EDGE = 2'b10;
endpackage

// File: rtl/mnd_cfg_decode.sv
module mnd_cfg_decode #(
   parameter int  MND_W   = 8,
   parameter bit  HAS_MND = 1'b1
) (
   input  logic [1:0]       mode,
   input  logic [MND_W-1:0] m_val,
   input  logic [MND_W-1:0] n_enc,
   input  logic [MND_W-1:0] d_enc,
   output logic [MND_W-1:0] n_val,
   output logic [MND_W-1:0] d_val,
   output logic             frac_on
);
   logic [MND_W-1:0] twice_d, d_req, d_lo, n_minus_m;

   // N recovered from its stored complement (R3)
   assign n_val     = (~n_enc) + m_val;
   // D recovered from complement of 2D (R4)
   assign twice_d   = ~d_enc;
   assign d_req     = twice_d >> 1;
   assign n_minus_m = n_val - m_val;
   // Clamp: lower bound M first, then upper bound N-M (R5)
   assign d_lo      = (d_req < m_val) ? m_val : d_req;
   assign d_val     = (d_lo > n_minus_m) ? n_minus_m : d_lo;

   generate
      if (HAS_MND) begin : g_frac
         assign frac_on = (mode == mnd_div_pkg::MODE_DUAL_EDGE) &&
                          (m_val != '0) && (m_val < n_val);
      end else begin : g_nofrac
         logic unused_mode;
         assign unused_mode = ^mode;
         assign frac_on     = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/mnd_halfstep_prediv.sv
module mnd_halfstep_prediv #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] code,
   input  logic             restart,
   output logic             pre_en
);
   localparam int AW = DIV_W + 1;

   logic [AW-1:0] acc, modulus, sum;
   logic          bypass;

   assign bypass  = (code < DIV_W'(2));
   assign modulus = {1'b0, code} + AW'(1);
   assign sum     = acc + AW'(2);
   assign pre_en  = bypass || (sum >= modulus);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 acc <= '0;
      else if (restart || bypass) acc <= '0;
      else if (sum >= modulus)    acc <= sum - modulus;
      else                        acc <= sum;
   end

   // Half-step accumulator stays inside its modulus (R2)
   assert_prediv_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bypass |-> (acc < modulus));
endmodule

// File: rtl/mnd_accum.sv
module mnd_accum #(
   parameter int MND_W   = 8,
   parameter bit HAS_MND = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pre_en,
   input  logic             frac_on,
   input  logic [MND_W-1:0] m_val,
   input  logic [MND_W-1:0] n_val,
   input  logic [MND_W-1:0] d_val,
   input  logic             restart,
   output logic             wrap,
   output logic             ce_o,
   output logic             level_o
);
   logic [MND_W-1:0] acc, acc_nxt;

   generate
      if (HAS_MND) begin : g_acc
         logic [MND_W:0] sum;
         assign sum     = {1'b0, acc} + {1'b0, m_val};
         assign wrap    = frac_on && pre_en && (sum >= {1'b0, n_val});
         assign acc_nxt = (sum >= {1'b0, n_val}) ? MND_W'(sum - {1'b0, n_val})
                                                : sum[MND_W-1:0];
      end else begin : g_noacc
         logic unused_in;
         assign unused_in = ^{m_val, n_val};
         assign wrap      = 1'b0;
         assign acc_nxt   = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         ce_o    <= 1'b0;
         level_o <= 1'b0;
      end else begin
         ce_o <= frac_on ? wrap : pre_en;
         if (restart) begin
            acc     <= '0;
            level_o <= 1'b0;
         end else if (pre_en) begin
            if (frac_on) begin
               acc     <= acc_nxt;
               level_o <= (acc_nxt < d_val);
            end else begin
               acc     <= '0;
               level_o <= ~level_o;
            end
         end
      end
   end

   // Accumulator never reaches N while fractional (R3)
   assert_acc_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frac_on |-> (acc < n_val));
   // An output pulse always follows a pre-enable one edge earlier (R8)
   assert_ce_follows_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ce_o |-> $past(pre_en));
endmodule

// File: rtl/mnd_frac_divider.sv
module mnd_frac_divider #(
   parameter int DIV_W   = 5,
   parameter int MND_W   = 8,
   parameter bit HAS_MND = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div_code,
   input  logic [1:0]       cfg_mode,
   input  logic [MND_W-1:0] cfg_m,
   input  logic [MND_W-1:0] cfg_n_enc,
   input  logic [MND_W-1:0] cfg_d_enc,
   output logic             ce_o,
   output logic             div_level_o
);
   generate
      if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div_w
         $error("mnd_frac_divider: DIV_W out of range");
      end
      if (MND_W < 2 || MND_W > 24) begin : g_bad_mnd_w
         $error("mnd_frac_divider: MND_W out of range");
      end
   endgenerate

   typedef struct packed {
      logic [DIV_W-1:0] div;
      logic [1:0]       mode;
      logic [MND_W-1:0] m;
      logic [MND_W-1:0] n_enc;
      logic [MND_W-1:0] d_enc;
   } cfg_t;

   cfg_t             cfg_in, act;
   logic [MND_W-1:0] n_val, d_val;
   logic             frac_on, pre_en, wrap, boundary, load;

   assign cfg_in = {cfg_div_code, cfg_mode, cfg_m, cfg_n_enc, cfg_d_enc};

   mnd_cfg_decode #(.MND_W(MND_W), .HAS_MND(HAS_MND)) u_dec (
      .mode(act.mode), .m_val(act.m), .n_enc(act.n_enc), .d_enc(act.d_enc),
      .n_val(n_val), .d_val(d_val), .frac_on(frac_on));

   mnd_halfstep_prediv #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .code(act.div), .restart(load), .pre_en(pre_en));

   mnd_accum #(.MND_W(MND_W), .HAS_MND(HAS_MND)) u_acc (
      .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .frac_on(frac_on),
      .m_val(act.m), .n_val(n_val), .d_val(d_val), .restart(load),
      .wrap(wrap), .ce_o(ce_o), .level_o(div_level_o));

   // Safe switch points: any cycle without fractional operation, else a wrap (R7)
   assign boundary = !frac_on || wrap;
   assign load     = boundary && (cfg_in != act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act <= '0;
      else if (load) act <= cfg_in;
   end

   // Active settings move only at a safe switch point (R7)
   assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(boundary) |-> $stable(act));
   // Decoded high time sits inside [M, N-M] whenever that range exists (R5)
   assert_d_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (frac_on && (act.m <= n_val - act.m)) |-> (d_val >= act.m && d_val <= n_val - act.m));
endmodule

// File: tb/sim_mnd_frac_divider.sv
module sim_mnd_frac_divider;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] div_code = '0;
   logic [1:0] mode = '0;
   logic [7:0] m_i = '0, n_enc = '0, d_enc = '0;
   logic       ce, lvl;
   int         n_tests = 0, n_fail = 0;

   always #5 clk = ~clk;

   mnd_frac_divider u0 (
      .clk(clk), .rst_n(rst_n), .cfg_div_code(div_code), .cfg_mode(mode),
      .cfg_m(m_i), .cfg_n_enc(n_enc), .cfg_d_enc(d_enc),
      .ce_o(ce), .div_level_o(lvl));

   task automatic check(string req, int got, int exp);
      n_tests++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic set_cfg(int code, logic [1:0] md, int m, int n, int d);
      logic [7:0] nm, d2;
      nm = 8'(n - m);
      d2 = 8'(2 * d);
      @(negedge clk);
      div_code = 5'(code);
      mode     = md;
      m_i      = 8'(m);
      n_enc    = ~nm;
      d_enc    = ~d2;
   endtask

   task automatic measure(int settle, int win, output int ce_cnt, output int hi_cnt);
      ce_cnt = 0;
      hi_cnt = 0;
      repeat (settle) @(negedge clk);
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         ce_cnt += int'(ce);
         hi_cnt += int'(lvl);
      end
   endtask

   task automatic gap_to_ce(output int k);
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!ce && k < 1000);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check("R1 ce in reset", int'(ce), 0);
      check("R1 level in reset", int'(lvl), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 first pulse after release", int'(ce), 1);
   endtask

   task automatic t_prediv;
      int c, h;
      set_cfg(0, 2'b00, 0, 0, 0);  measure(50, 300, c, h);
      check("R2 code0 bypass", c, 300);
      set_cfg(1, 2'b00, 0, 0, 0);  measure(50, 300, c, h);
      check("R2 code1 bypass", c, 300);
      set_cfg(2, 2'b00, 0, 0, 0);  measure(50, 300, c, h);
      check("R2 code2 div1.5", c, 200);
      set_cfg(3, 2'b00, 0, 0, 0);  measure(50, 300, c, h);
      check("R2 code3 div2", c, 150);
      check("R6 code3 level 50pct", h, 150);
      set_cfg(4, 2'b00, 0, 0, 0);  measure(50, 300, c, h);
      check("R2 code4 div2.5", c, 120);
   endtask

   task automatic t_frac;
      int c, h;
      set_cfg(0, 2'b10, 1, 3, 1);  measure(100, 300, c, h);
      check("R3 m1 n3 pulses", c, 100);
      check("R4 m1 n3 d1 high", h, 100);
      set_cfg(0, 2'b10, 3, 8, 4);  measure(100, 800, c, h);
      check("R3 m3 n8 pulses", c, 300);
      check("R4 m3 n8 d4 high", h, 400);
      set_cfg(2, 2'b10, 1, 4, 2);  measure(100, 1200, c, h);
      check("R2 R3 prediv1.5 then 1/4", c, 200);
   endtask

   task automatic t_clamp;
      int c, h;
      set_cfg(0, 2'b10, 3, 10, 1); measure(100, 1000, c, h);
      check("R5 low clamp pulses", c, 300);
      check("R5 low clamp high", h, 300);
      set_cfg(0, 2'b10, 2, 7, 6);  measure(100, 700, c, h);
      check("R5 high clamp pulses", c, 200);
      check("R5 high clamp high", h, 500);
   endtask

   task automatic t_bypass_modes;
      int c, h;
      set_cfg(0, 2'b00, 1, 3, 1);  measure(100, 300, c, h);
      check("R6 mode00 ignores M/N", c, 300);
      check("R6 mode00 level 50pct", h, 150);
      set_cfg(0, 2'b10, 5, 5, 2);  measure(100, 300, c, h);
      check("R6 M equals N bypass", c, 300);
      set_cfg(0, 2'b10, 0, 0, 0);
      m_i = '0; n_enc = '0; d_enc = '0;
      measure(100, 300, c, h);
      check("R6 all zero pulses", c, 300);
      check("R6 all zero level 50pct", h, 150);
   endtask

   task automatic t_switch;
      int k;
      set_cfg(0, 2'b10, 1, 8, 4);
      repeat (100) @(negedge clk);
      gap_to_ce(k);
      repeat (3) @(negedge clk);
      div_code = '0; mode = 2'b10; m_i = 8'd1; n_enc = ~8'd2; d_enc = ~8'd2;
      gap_to_ce(k);
      check("R7 running period completes", k + 3, 8);
      gap_to_ce(k);
      check("R7 new period from zero", k, 3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_prediv();
      t_frac();
      t_clamp();
      t_bypass_modes();
      t_switch();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule